// File: doc/BRIEF.md
# AES-128 Key Schedule Register Unit

This block keeps a 16-byte AES-128 key in a small byte-addressed store and walks the key schedule through it, one round key per clock. In encryption mode it starts from the cipher key and steps forward ten times, so that when it finishes the store holds the tenth round key. In decryption mode it starts from the tenth round key and steps backward ten times, so that when it finishes the store holds the original cipher key.

A host loads the key one byte at a time through a write pointer that advances by itself. It reads the key back through a separate read pointer that also advances by itself. A control-register strobe clears both pointers and can start a run in either mode. While a run is in progress `busy` stays high. One cycle after the last step, `done` pulses for one clock, and that pulse can serve as a DMA request.

A common use is to make the decryption key. The host runs a dummy encryption with the cipher key and then reads the store, which now holds the last round key needed for decryption.

Top module: `aes128_key_store`

## Requirements
- R1: After reset, both pointers are zero, every key byte reads 0x00, and `busy` and `done` are low.
- R2: Each `key_we` pulse stores `key_wdata` at the write pointer and then advances the pointer by one. The pointer is 4 bits wide, so the 17th byte wraps around to byte 0.
- R3: `key_rdata` always shows the byte at the read pointer. Each `key_re` pulse advances the read pointer by one, independently of the write pointer. Byte 0 is the first byte of the key as written in hex.
- R4: Any cycle with `ctl_we` high clears both pointers to zero, with or without a start. Pointer clearing takes priority over a key write or read in the same cycle.
- R5: Before any run, reading the 16 bytes returns exactly the bytes that were loaded.
- R6: A run with `ctl_dec`=0 replaces the store with the tenth AES-128 round key derived from the stored key. For example, 2b7e151628aed2a6abf7158809cf4f3c becomes d014f9a8c9ee2589e13f0cc8b6630ca6.
- R7: A run with `ctl_dec`=1 treats the store as a tenth round key and restores the cipher key it came from. Decryption applies the round constants in descending order.
- R8: A start (`ctl_we` and `ctl_start` both high while idle) makes `busy` high for exactly 10 cycles. A start issued while busy is ignored.
- R9: `done` is high for exactly one cycle, which is the first cycle after `busy` falls.
- R10: Key writes while `busy` is high change neither the store nor the write pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control-register access strobe; clears both pointers |
| ctl_start | input | 1 | With `ctl_we`, starts a run |
| ctl_dec | input | 1 | Mode for the run being started: 0 = encrypt, 1 = decrypt |
| key_we | input | 1 | Key byte write strobe |
| key_wdata | input | 8 | Key byte to write |
| key_re | input | 1 | Key byte read strobe; advances the read pointer |
| key_rdata | output | 8 | Key byte at the read pointer |
| busy | output | 1 | High while the schedule is stepping |
| done | output | 1 | One-cycle completion trigger |

## Verification
The schedule is tested with two keys: the standard published test key, and the all-zero key. Each key is run forward, and the resulting round key is then run backward. The published key exercises all four S-box lookups with non-trivial bytes. The zero key isolates the round-constant path, because in that case every non-zero byte of the first step comes only from Rcon and S-box(0). Running each result back in decryption mode separates a correct inverse from one that applies the round constants in the wrong order. Separate directed sequences cover pointer wrap, pointer clearing, a start issued while busy, and writes issued while busy.

// File: rtl/aes128_key_store.sv
module aes128_key_store (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic       ctl_start,
  input  logic       ctl_dec,
  input  logic       key_we,
  input  logic [7:0] key_wdata,
  input  logic       key_re,
  output logic [7:0] key_rdata,
  output logic       busy,
  output logic       done
);
  localparam int NROUND = 10;

  logic [127:0] kq;
  logic [3:0]   wptr, rptr;
  logic [3:0]   rnd;
  logic         dec_q;

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
    end
    return p;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] sq, inv;
    sq  = a;
    inv = 8'h01;
    for (int k = 1; k < 8; k++) begin
      sq  = gmul(sq, sq);
      inv = gmul(inv, sq);
    end
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
               ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [31:0] subrot(input logic [31:0] w);
    return {sbox(w[23:16]), sbox(w[15:8]), sbox(w[7:0]), sbox(w[31:24])};
  endfunction

  function automatic logic [7:0] rcon(input logic [3:0] i);
    logic [7:0] r;
    r = 8'h01;
    for (int k = 0; k < NROUND; k++)
      if (k < int'(i)) r = {r[6:0], 1'b0} ^ (r[7] ? 8'h1b : 8'h00);
    return r;
  endfunction

  logic [31:0] w0, w1, w2, w3;
  logic [31:0] rc;
  logic [31:0] f0, f1, f2, f3;
  logic [31:0] b0, b1, b2, b3;

  assign {w0, w1, w2, w3} = kq;
  assign rc = {rcon(dec_q ? 4'(NROUND - 1) - rnd : rnd), 24'h0};

  assign f0 = w0 ^ subrot(w3) ^ rc;
  assign f1 = w1 ^ f0;
  assign f2 = w2 ^ f1;
  assign f3 = w3 ^ f2;

  assign b3 = w3 ^ w2;
  assign b2 = w2 ^ w1;
  assign b1 = w1 ^ w0;
  assign b0 = w0 ^ subrot(b3) ^ rc;

  assign key_rdata = kq[8*(15 - int'(rptr)) +: 8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kq    <= '0;
      wptr  <= '0;
      rptr  <= '0;
      rnd   <= '0;
      dec_q <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        kq <= dec_q ? {b0, b1, b2, b3} : {f0, f1, f2, f3};
        if (rnd == 4'(NROUND - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
          rnd  <= '0;
        end else begin
          rnd <= rnd + 4'd1;
        end
      end else if (key_we && !ctl_we) begin
        kq[8*(15 - int'(wptr)) +: 8] <= key_wdata;
      end
      if (ctl_we) begin
        wptr <= '0;
        rptr <= '0;
        if (ctl_start && !busy) begin
          busy  <= 1'b1;
          dec_q <= ctl_dec;
          rnd   <= '0;
        end
      end else begin
        if (key_we && !busy) wptr <= wptr + 4'd1;
        if (key_re)          rptr <= rptr + 4'd1;
      end
    end
  end

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  a_r4_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_we) |-> (wptr == 4'd0 && rptr == 4'd0));
  a_r8_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ctl_we && ctl_start));
  a_r8_round_range: assert property (@(posedge clk) disable iff (!rst_n)
    rnd <= 4'(NROUND - 1));
  a_r10_wptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ctl_we) |=> $stable(wptr));
endmodule

// File: tb/sim_aes128_key_store.sv
module sim_aes128_key_store;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 0, ctl_start = 0, ctl_dec = 0, key_we = 0, key_re = 0;
  logic [7:0] key_wdata = 0;
  logic [7:0] key_rdata;
  logic busy, done;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  aes128_key_store u0 (.clk, .rst_n, .ctl_we, .ctl_start, .ctl_dec, .key_we,
    .key_wdata, .key_re, .key_rdata, .busy, .done);

  localparam logic [127:0] VK [4] = '{
    128'h2b7e151628aed2a6abf7158809cf4f3c, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6,
    128'h00000000000000000000000000000000, 128'hb4ef5bcb3e92e21123e951cf6f8f188e};
  localparam logic [3:0] VD = 4'b1010;
  localparam logic [127:0] VE [4] = '{
    128'hd014f9a8c9ee2589e13f0cc8b6630ca6, 128'h2b7e151628aed2a6abf7158809cf4f3c,
    128'hb4ef5bcb3e92e21123e951cf6f8f188e, 128'h00000000000000000000000000000000};

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); key_we = 1; key_wdata = d;
    @(negedge clk); key_we = 0;
  endtask

  task automatic rd(output logic [7:0] d);
    @(negedge clk); d = key_rdata; key_re = 1;
    @(negedge clk); key_re = 0;
  endtask

  task automatic ctl(input logic st, input logic dc);
    @(negedge clk); ctl_we = 1; ctl_start = st; ctl_dec = dc;
    @(negedge clk); ctl_we = 0; ctl_start = 0;
  endtask

  task automatic load(input logic [127:0] k);
    ctl(0, 0);
    for (int i = 0; i < 16; i++) wr(k[127-8*i -: 8]);
  endtask

  task automatic rdall(output logic [127:0] k);
    logic [7:0] b;
    ctl(0, 0);
    for (int i = 0; i < 16; i++) begin rd(b); k[127-8*i -: 8] = b; end
  endtask

  task automatic run(input logic dc, output int nb);
    ctl(1, dc);
    nb = 0;
    while (busy && nb < 50) begin nb++; @(negedge clk); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [127:0] k;
    logic [7:0] b;
    int nb;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy/done", {busy, done}, 0);
    chk("R1 rdata", key_rdata, 0);
    rdall(k);
    chk("R1 key zero", k, 0);

    for (int v = 0; v < 4; v++) begin
      load(VK[v]);
      rdall(k);
      chk("R5 readback", k, VK[v]);
      run(VD[v], nb);
      chk("R8 busy cycles", nb, 10);
      chk("R9 done pulse", done, 1);
      @(negedge clk);
      chk("R9 done drop", done, 0);
      rdall(k);
      chk(VD[v] ? "R7 decrypt" : "R6 encrypt", k, VE[v]);
    end

    load(128'h000102030405060708090a0b0c0d0e0f);
    wr(8'hee);
    ctl(0, 0);
    rd(b); chk("R2 wrap byte0", b, 8'hee);
    rd(b); chk("R3 read adv", b, 8'h01);
    rd(b); chk("R3 read adv2", b, 8'h02);
    wr(8'h55);
    rd(b); chk("R3 independent", b, 8'h03);
    ctl(0, 0);
    rd(b); chk("R4 rptr clear", b, 8'h55);
    @(negedge clk); ctl_we = 1; key_we = 1; key_wdata = 8'h77;
    @(negedge clk); ctl_we = 0; key_we = 0;
    wr(8'h99);
    rdall(k);
    chk("R4 wptr clear", k[127:112], 16'h9901);

    load(VK[0]);
    ctl(1, 0);
    wr(8'hff);
    @(negedge clk); ctl_we = 1; ctl_start = 1; ctl_dec = 1;
    @(negedge clk); ctl_we = 0; ctl_start = 0;
    nb = 0;
    while (busy && nb < 50) begin nb++; @(negedge clk); end
    chk("R8 start ignored", nb, 6);
    @(negedge clk);
    wr(8'haa);
    rdall(k);
    chk("R10 write ignored", k, {8'haa, VE[0][119:0]});

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule